// File: doc/BRIEF.md
# Up/Down Timer Channel with Clearable Status Flags

This block is one channel of a general-purpose timer. A free-running counter moves by one step on each count tick, up or down according to a direction input. Two general registers sit beside the counter. Each works either as a compare register, raising its flag when the counter reaches its value, or as a capture register, latching the counter when its capture strobe arrives. Wrapping past the top or bottom of the count range raises an overflow or an underflow flag.

Software uses a small register bus to reach the control byte, the status byte, the counter and the two general registers. A flag cannot be dropped by a blind write. Software first has to read the flag as 1, and its next status write then clears it by writing 0 in that bit position. A handshake from a transfer engine can also drop the A and B flags directly. Each of the four event flags drives its own interrupt request, gated by an enable bit.

Each flag is handled by a three-state machine:
- `FL_CLEAR`: the flag is 0.
- `FL_SET`: the flag is 1 but has not been read.
- `FL_ARMED`: the flag is 1 and has been read as 1.

Its transitions are:
- set event: `FL_CLEAR`→`FL_SET`.
- status read: `FL_SET`→`FL_ARMED`.
- status write with a 0 in the flag's bit: `FL_ARMED`→`FL_CLEAR`.
- status write with a 1 in the flag's bit: `FL_ARMED`→`FL_SET`.
- engine acknowledge: `FL_SET`/`FL_ARMED`→`FL_CLEAR`, for A and B only.
- A set event forces `FL_SET` whenever the other rules would lead to `FL_CLEAR`.

Top module: `updn_timer_ch`

## Requirements
- R1: After reset the counter, both general registers and the control byte are 0. The status word (address 1) reads 0x00C0, and all interrupt requests are low.
- R2: The bus map places control at address 0, status at 1, counter at 2, general register A at 3 and general register B at 4. A counter write has priority over a tick. The direction input is registered each clock, with a reset value of 1. On each tick the counter adds 1 when that register is 1 and subtracts 1 when it is 0. Status bit 7 reads the register.
- R3: A tick that takes the counter from 0xFFFF to 0x0000 sets the overflow flag, which is status bit 4.
- R4: A tick that takes the counter from 0x0000 to 0xFFFF sets the underflow flag, which is status bit 5.
- R5: Control bit 0 selects the mode of register A and control bit 1 the mode of register B; 0 means compare. In compare mode, a tick that brings the counter to the register's value sets the register's flag. Flag A is status bit 0 and flag B is status bit 1.
- R6: In capture mode (control bit = 1), a one-cycle capture strobe copies the counter into the register and sets its flag.
- R7: A status write of 0 in a flag's bit clears the flag only if a status read returned that flag as 1 after the last status write. A status write consumes every armed flag. A write of 0 without such a read, or a write of 1, leaves the flag set.
- R8: An acknowledge for A or B clears that flag when the no-clear input is 0 and has no effect when it is 1.
- R9: When a set event and a clear of the same flag fall in one cycle, the flag ends up set.
- R10: Status bit 6 always reads 1 and bits 3 and 2 always read 0. Writes to these bits and to bit 7 change nothing.
- R11: Control bits 2, 3, 4 and 5 enable the interrupts for flag A, flag B, overflow and underflow. Each request is its flag ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (status reads arm flags) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| tick | input | 1 | Count enable, one step per cycle |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| cap_a | input | 1 | Capture strobe for register A |
| cap_b | input | 1 | Capture strobe for register B |
| ack_a | input | 1 | Transfer-engine acknowledge for A |
| ack_b | input | 1 | Transfer-engine acknowledge for B |
| ack_noclr | input | 1 | 1 = acknowledges leave flags alone |
| irq_a | output | 1 | Interrupt request, flag A |
| irq_b | output | 1 | Interrupt request, flag B |
| irq_ovf | output | 1 | Interrupt request, overflow |
| irq_unf | output | 1 | Interrupt request, underflow |

## Verification
Four kinds of clear attempt are tried on set flags:
- a plain 0 write with no read first;
- a read followed by a write of 1 and then a second write of 0;
- a read followed by a 0 write in the same cycle as a new set event;
- acknowledges with the no-clear input at 1 and at 0.

Together these separate a clear that needs a prior read from one that does not, show that a write consumes the armed state, and confirm that a set event wins over a clear. The counter is stepped across the top wrap and the bottom wrap. Compare matches are hit in both directions, and a capture is taken from a counter value loaded by software.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;
    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_SET   = 2'd1,
        FL_ARMED = 2'd2
    } flag_st_e;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_STAT = 3'd1;
    localparam logic [2:0] ADR_CNT  = 3'd2;
    localparam logic [2:0] ADR_GRA  = 3'd3;
    localparam logic [2:0] ADR_GRB  = 3'd4;

    localparam int unsigned NUM_FLAGS = 4;
    // flag index -> status bit: A, B, overflow, underflow
    localparam int unsigned FLAG_BIT [NUM_FLAGS] = '{0, 1, 4, 5};
endpackage

// File: rtl/updn_tmr_counter.sv
module updn_tmr_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         up,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         step,
    output logic         wrap_hi,
    output logic         wrap_lo
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_nxt = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
        step    = tick && !ld;
        wrap_hi = step && up  && (cnt_q == MAXV);
        wrap_lo = step && !up && (cnt_q == '0);
        cnt     = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (ld)   cnt_q <= ld_val;
        else if (step) cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/updn_tmr_greg.sv
module updn_tmr_greg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_mode,
    input  logic         cap,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cnt_nxt,
    input  logic         step,
    output logic [W-1:0] gr,
    output logic         evt
);
    logic [W-1:0] gr_q;

    always_comb begin
        evt = cap_mode ? cap : (step && (cnt_nxt == gr_q));
        gr  = gr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               gr_q <= '0;
        else if (cap_mode && cap) gr_q <= cnt;
        else if (wr)              gr_q <= wdata;
    end
endmodule

// File: rtl/updn_tmr_flag.sv
module updn_tmr_flag
    import updn_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic hw_clr,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wbit,
    output logic flag
);
    flag_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (hw_clr) begin
            st_d = FL_CLEAR;
        end else begin
            unique case (st_q)
                FL_CLEAR: st_d = FL_CLEAR;
                FL_SET:   st_d = rd_hit ? FL_ARMED : FL_SET;
                FL_ARMED: if (wr_hit) st_d = wbit ? FL_SET : FL_CLEAR;
                default:  st_d = FL_CLEAR;
            endcase
        end
        if (set_evt && st_d == FL_CLEAR) st_d = FL_SET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FL_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        flag = (st_q != FL_CLEAR);
    end
endmodule

// File: rtl/updn_timer_ch.sv
module updn_timer_ch
    import updn_tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              tick,
    input  logic              dir_up,
    input  logic              cap_a,
    input  logic              cap_b,
    input  logic              ack_a,
    input  logic              ack_b,
    input  logic              ack_noclr,
    output logic              irq_a,
    output logic              irq_b,
    output logic              irq_ovf,
    output logic              irq_unf
);
    localparam int unsigned CTRL_W = 6;
    localparam int unsigned PAD_W  = CNT_W - 8;

    logic [CTRL_W-1:0] ctrl_q;
    logic              dir_q;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    logic              step, wrap_hi, wrap_lo;
    logic [CNT_W-1:0]  gr_q [2];
    logic [1:0]        gr_evt, cap_vec, ack_vec, gr_wr;
    logic [NUM_FLAGS-1:0] set_evt, hw_clr, flag;
    logic [7:0]        stat_byte;
    logic              stat_rd, stat_wr, cnt_wr;

    always_comb begin
        stat_rd = rd_en && (addr == ADDR_W'(ADR_STAT));
        stat_wr = wr_en && (addr == ADDR_W'(ADR_STAT));
        cnt_wr  = wr_en && (addr == ADDR_W'(ADR_CNT));
        gr_wr   = {wr_en && (addr == ADDR_W'(ADR_GRB)),
                   wr_en && (addr == ADDR_W'(ADR_GRA))};
        cap_vec = {cap_b, cap_a};
        ack_vec = {ack_b, ack_a};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dir_q  <= 1'b1;
        end else begin
            dir_q <= dir_up;
            if (wr_en && addr == ADDR_W'(ADR_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

    updn_tmr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .up(dir_q),
        .ld(cnt_wr), .ld_val(wdata), .cnt(cnt_q), .cnt_nxt(cnt_nxt),
        .step(step), .wrap_hi(wrap_hi), .wrap_lo(wrap_lo)
    );

    for (genvar g = 0; g < 2; g++) begin : g_greg
        updn_tmr_greg #(.W(CNT_W)) u_greg (
            .clk(clk), .rst_n(rst_n), .cap_mode(ctrl_q[g]), .cap(cap_vec[g]),
            .wr(gr_wr[g]), .wdata(wdata), .cnt(cnt_q), .cnt_nxt(cnt_nxt),
            .step(step), .gr(gr_q[g]), .evt(gr_evt[g])
        );
    end

    always_comb begin
        set_evt = {wrap_lo, wrap_hi, gr_evt};
        hw_clr  = {2'b00, ack_vec & {2{!ack_noclr}}};
    end

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        updn_tmr_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_evt(set_evt[f]), .hw_clr(hw_clr[f]),
            .rd_hit(stat_rd), .wr_hit(stat_wr), .wbit(wdata[FLAG_BIT[f]]),
            .flag(flag[f])
        );
    end

    always_comb begin
        stat_byte = {dir_q, 1'b1, flag[3], flag[2], 2'b00, flag[1], flag[0]};
        unique case (addr)
            ADDR_W'(ADR_CTRL): rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
            ADDR_W'(ADR_STAT): rdata = {{PAD_W{1'b0}}, stat_byte};
            ADDR_W'(ADR_CNT):  rdata = cnt_q;
            ADDR_W'(ADR_GRA):  rdata = gr_q[0];
            ADDR_W'(ADR_GRB):  rdata = gr_q[1];
            default:           rdata = '0;
        endcase
        irq_a   = flag[0] && ctrl_q[2];
        irq_b   = flag[1] && ctrl_q[3];
        irq_ovf = flag[2] && ctrl_q[4];
        irq_unf = flag[3] && ctrl_q[5];
    end
endmodule

// File: rtl/updn_tmr_chk.sv
module updn_tmr_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        stat,
    input logic [CNT_W-1:0]  cnt,
    input logic              tick,
    input logic              dir_q,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        wbits,
    input logic              ack_a,
    input logic              ack_noclr
);
    logic stat_wr, cnt_wr;
    always_comb begin
        stat_wr = wr_en && (addr == ADDR_W'(1));
        cnt_wr  = wr_en && (addr == ADDR_W'(2));
    end

    assert_rsvd_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat[6] && (stat[3:2] == 2'b00));

    assert_ovf_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dir_q && !cnt_wr && cnt == {CNT_W{1'b1}}) |=> (cnt == '0 && stat[4]));

    assert_unf_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dir_q && !cnt_wr && cnt == '0) |=> (cnt == {CNT_W{1'b1}} && stat[5]));

    assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[4]) |-> $past(stat_wr && !wbits[1]));

    assert_a_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[0]) |-> $past((stat_wr && !wbits[0]) || (ack_a && !ack_noclr)));
endmodule

bind updn_timer_ch updn_tmr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stat(stat_byte), .cnt(cnt_q), .tick(tick),
    .dir_q(dir_q), .wr_en(wr_en), .addr(addr), .wbits({wdata[4], wdata[0]}),
    .ack_a(ack_a), .ack_noclr(ack_noclr)
);

// File: tb/updn_timer_ch_tb.sv
module updn_timer_ch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        tick = 1'b0, dir_up = 1'b1;
    logic        cap_a = 1'b0, cap_b = 1'b0;
    logic        ack_a = 1'b0, ack_b = 1'b0, ack_noclr = 1'b0;
    logic        irq_a, irq_b, irq_ovf, irq_unf;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    updn_timer_ch u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tick(tick), .dir_up(dir_up),
        .cap_a(cap_a), .cap_b(cap_b), .ack_a(ack_a), .ack_b(ack_b),
        .ack_noclr(ack_noclr), .irq_a(irq_a), .irq_b(irq_b),
        .irq_ovf(irq_ovf), .irq_unf(irq_unf)
    );

    // monitor: pops expected read data while a read is on the bus
    always @(negedge clk) begin
        if (rd_en && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic chk_irq(input logic [3:0] e, input string t);
        @(negedge clk);
        n_cmp++;
        if ({irq_unf, irq_ovf, irq_b, irq_a} !== e) begin
            n_bad++;
            $display("FAIL %s: irq=%b expected=%b", t, {irq_unf, irq_ovf, irq_b, irq_a}, e);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        // R1 reset state
        rd(3'd1, 16'h00C0, "R1 status");
        rd(3'd2, 16'h0000, "R1 count");
        rd(3'd3, 16'h0000, "R1 gra");
        chk_irq(4'b0000, "R1 irq");
        // R5/R11 compare on A
        wr(3'd0, 16'h003C);
        wr(3'd3, 16'h0005);
        wr(3'd4, 16'h0100);
        ticks(5);
        chk_irq(4'b0001, "R5 R11 irq_a after compare");
        // R7 blind write of 0 leaves flag set
        wr(3'd1, 16'h0000);
        rd(3'd1, 16'h00C1, "R7 blind write ignored");
        wr(3'd1, 16'h0000);
        rd(3'd1, 16'h00C0, "R7 read-then-write clears");
        chk_irq(4'b0000, "R11 irq_a dropped");
        rd(3'd2, 16'h0005, "R2 count up");
        // R3 overflow and compare on B
        wr(3'd2, 16'hFFFE);
        wr(3'd4, 16'hFFFF);
        ticks(2);
        rd(3'd2, 16'h0000, "R3 count wrapped");
        rd(3'd1, 16'h00D2, "R3 R5 ovf and B set");
        wr(3'd1, 16'h0010);
        wr(3'd1, 16'h0000);
        rd(3'd1, 16'h00D0, "R7 write consumes arm");
        wr(3'd1, 16'h0000);
        rd(3'd1, 16'h00C0, "R7 ovf cleared");
        // R4 underflow, direction flag
        dir_up = 1'b0;
        idle();
        ticks(1);
        rd(3'd2, 16'hFFFF, "R4 count wrapped down");
        chk_irq(4'b1010, "R4 R11 irq_unf irq_b");
        rd(3'd1, 16'h0062, "R2 R4 dir and unf");
        wr(3'd1, 16'h0000);
        rd(3'd1, 16'h0040, "R7 unf cleared");
        // R6 capture on A
        wr(3'd0, 16'h003D);
        wr(3'd2, 16'h1234);
        cap_a = 1'b1; idle(); cap_a = 1'b0;
        rd(3'd3, 16'h1234, "R6 captured value");
        rd(3'd1, 16'h0041, "R6 capture flag");
        // R8 acknowledge
        ack_noclr = 1'b1; ack_a = 1'b1; idle(); ack_a = 1'b0;
        rd(3'd1, 16'h0041, "R8 ack with no-clear ignored");
        ack_noclr = 1'b0; ack_a = 1'b1; idle(); ack_a = 1'b0;
        rd(3'd1, 16'h0040, "R8 ack clears");
        // R9 set wins over clear
        cap_a = 1'b1; idle(); cap_a = 1'b0;
        rd(3'd1, 16'h0041, "R9 flag set before race");
        cap_a = 1'b1; wr(3'd1, 16'h0000); cap_a = 1'b0;
        rd(3'd1, 16'h0041, "R9 set wins");
        wr(3'd1, 16'h0000);
        rd(3'd1, 16'h0040, "R9 cleared after");
        // R10 reserved and read-only bits
        wr(3'd1, 16'hFFFF);
        rd(3'd1, 16'h0040, "R10 write to fixed bits ignored");
        // R2 count again upward
        dir_up = 1'b1;
        wr(3'd2, 16'h0010);
        ticks(3);
        rd(3'd2, 16'h0013, "R2 count after re-direction");
        rd(3'd1, 16'h00C0, "R2 dir flag up");
        idle();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule